// File: doc/BRIEF.md
# Rotating Permutation Scheduler for an Event-Building Crossbar

This block sets the connection pattern of an N-by-N crossbar that joins readout buffers (sources) to builder units (destinations). It does not arbitrate on requests. It steps through the cyclic permutations of the destination set. Time is cut into slots of a fixed number of clock cycles. In every slot, source i is joined to destination (i + offset) mod N. The offset starts at zero and rises by one at each slot boundary, wrapping from N-1 to 0. Because every slot's pattern is a permutation, no output is ever claimed by two sources. The switch can therefore carry nearly its full input bandwidth with no blocking and no loss.

The buffer logic beside the block places event e in the queue for destination e mod N. Every fragment of one event then meets the same builder. Each source reports, with one bit per destination, whether it holds a fragment for that destination. In the first cycle of a slot, a source receives a one-cycle grant strobe if it holds a fragment for its mapped destination and that destination is ready. The selected destination then sees the source's data with a valid flag for the whole slot. A source with nothing for its mapped destination, or whose destination is not ready, idles for that slot. The rotation carries on in every case, so every source visits every destination once per N slots and each buffer drains at a steady share of the link.

Top module: `bshift_evb_sched`

## Requirements
- R1: While rst_ni is low, slot_offset_o is 0, field d of xbar_sel_o equals d, and grant_o and dst_valid_o are 0 when no fragment is available.
- R2: A slot lasts SLOT_CYCLES clock cycles. The first slot after reset has offset 0. slot_offset_o holds its value within a slot and increases by one at each boundary, wrapping from N_PORTS-1 to 0.
- R3: Field d of xbar_sel_o (IDX_W bits at bit d*IDX_W) holds the source feeding destination d, equal to (d - offset) mod N_PORTS. In every cycle the fields form a permutation of the source indices.
- R4: grant_o[i] is high only in the first cycle of a slot. It is high exactly when frag_avail_i[i*N_PORTS + m] and dst_ready_i[m] are both 1, where m = (i + offset) mod N_PORTS.
- R5: When dst_ready_i[m] is 0 in the first cycle of a slot, the source mapped to destination m gets no grant in that slot, and the offset still advances at the slot boundary.
- R6: dst_valid_o[d] is high in every cycle of a slot exactly when the source mapped to d was granted in that slot's first cycle. dst_data_o word d (DATA_W bits at bit d*DATA_W) always equals src_data_i word (d - offset) mod N_PORTS.
- R7: Over each run of N_PORTS consecutive slots that starts at a slot whose index is a multiple of N_PORTS, every source is mapped to every destination exactly once.
- R8: A fragment-available bit for any destination other than the one mapped to a source in the current slot has no effect on that source's grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frag_avail_i | input | N_PORTS*N_PORTS | Bit i*N_PORTS+d: source i holds a fragment for destination d |
| dst_ready_i | input | N_PORTS | Destination d can accept a transfer |
| src_data_i | input | N_PORTS*DATA_W | Data word of each source |
| grant_o | output | N_PORTS | One-cycle strobe at slot start: source may send this slot |
| xbar_sel_o | output | N_PORTS*IDX_W | Source index driving each destination |
| slot_offset_o | output | IDX_W | Current permutation offset |
| dst_data_o | output | N_PORTS*DATA_W | Data word delivered to each destination |
| dst_valid_o | output | N_PORTS | Destination receives a granted transfer this slot |

## Verification
The assertions take two things for granted. The first is that dst_ready_i is sampled only at the first cycle of a slot. The second is that availability can change in any cycle without disturbing a slot already granted. The stimulus keeps within these by changing all inputs at the falling edge in every cycle, including cycles in the middle of a slot. The bench's expected valid flags must therefore come from the slot-start value alone. The stimulus passes through four kinds of slot: every fragment present with all destinations ready, pseudo-random availability and readiness, fragments only for the wrong destination, and all destinations stalled. It runs long enough for the offset to wrap several times.

// File: rtl/ebs_pkg.sv
package ebs_pkg;
  function automatic int unsigned mod_add(int unsigned a, int unsigned b, int unsigned n);
    int unsigned s;
    s = a + b;
    return (s >= n) ? s - n : s;
  endfunction

  function automatic int unsigned mod_sub(int unsigned a, int unsigned b, int unsigned n);
    return (a >= b) ? a - b : a + n - b;
  endfunction
endpackage

// File: rtl/ebs_slot_timer.sv
module ebs_slot_timer #(
  parameter int unsigned N_PORTS     = 4,
  parameter int unsigned SLOT_CYCLES = 4,
  parameter int unsigned IDX_W       = 2,
  parameter int unsigned CYC_W       = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic             slot_first_o,
  output logic [IDX_W-1:0] offset_o
);
  logic [CYC_W-1:0] cyc_q;
  logic [IDX_W-1:0] off_q;
  logic             slot_last;

  assign slot_last    = (cyc_q == CYC_W'(SLOT_CYCLES - 1));
  assign slot_first_o = (cyc_q == '0);
  assign offset_o     = off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q <= '0;
      off_q <= '0;
    end else if (slot_last) begin
      cyc_q <= '0;
      off_q <= (off_q == IDX_W'(N_PORTS - 1)) ? '0 : off_q + 1'b1;
    end else begin
      cyc_q <= cyc_q + 1'b1;
    end
  end
endmodule

// File: rtl/ebs_perm_map.sv
module ebs_perm_map
  import ebs_pkg::*;
#(
  parameter int unsigned N_PORTS = 4,
  parameter int unsigned IDX_W   = 2
) (
  input  logic [IDX_W-1:0]         offset_i,
  output logic [N_PORTS*IDX_W-1:0] dst_src_o,
  output logic [N_PORTS*IDX_W-1:0] src_dst_o
);
  for (genvar g = 0; g < N_PORTS; g++) begin : g_map
    assign dst_src_o[g*IDX_W +: IDX_W] = IDX_W'(mod_sub(g, 32'(offset_i), N_PORTS));
    assign src_dst_o[g*IDX_W +: IDX_W] = IDX_W'(mod_add(g, 32'(offset_i), N_PORTS));
  end
endmodule

// File: rtl/ebs_grant_xbar.sv
module ebs_grant_xbar #(
  parameter int unsigned N_PORTS = 4,
  parameter int unsigned IDX_W   = 2,
  parameter int unsigned DATA_W  = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         slot_first_i,
  input  logic [N_PORTS*N_PORTS-1:0]   frag_avail_i,
  input  logic [N_PORTS-1:0]           dst_ready_i,
  input  logic [N_PORTS*IDX_W-1:0]     src_dst_i,
  input  logic [N_PORTS*IDX_W-1:0]     dst_src_i,
  input  logic [N_PORTS*DATA_W-1:0]    src_data_i,
  output logic [N_PORTS-1:0]           grant_o,
  output logic [N_PORTS*DATA_W-1:0]    dst_data_o,
  output logic [N_PORTS-1:0]           dst_valid_o
);
  logic [N_PORTS-1:0] hold_q;
  logic [N_PORTS-1:0] live;
  logic [DATA_W-1:0]  words [N_PORTS];

  for (genvar g = 0; g < N_PORTS; g++) begin : g_src
    logic [N_PORTS-1:0] row;
    logic [IDX_W-1:0]   dst;
    assign row        = frag_avail_i[g*N_PORTS +: N_PORTS];
    assign dst        = src_dst_i[g*IDX_W +: IDX_W];
    assign grant_o[g] = slot_first_i & row[dst] & dst_ready_i[dst];
    assign live[g]    = slot_first_i ? grant_o[g] : hold_q[g];
    assign words[g]   = src_data_i[g*DATA_W +: DATA_W];
  end

  // grant taken at slot start stays valid for the rest of the slot
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           hold_q <= '0;
    else if (slot_first_i) hold_q <= grant_o;
  end

  for (genvar g = 0; g < N_PORTS; g++) begin : g_dst
    logic [IDX_W-1:0] src;
    assign src                          = dst_src_i[g*IDX_W +: IDX_W];
    assign dst_valid_o[g]               = live[src];
    assign dst_data_o[g*DATA_W +: DATA_W] = words[src];
  end
endmodule

// File: rtl/bshift_evb_sched.sv
module bshift_evb_sched #(
  parameter int unsigned N_PORTS     = 4,
  parameter int unsigned SLOT_CYCLES = 4,
  parameter int unsigned DATA_W      = 16,
  localparam int unsigned IDX_W      = (N_PORTS > 1) ? $clog2(N_PORTS) : 1,
  localparam int unsigned CYC_W      = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N_PORTS*N_PORTS-1:0] frag_avail_i,
  input  logic [N_PORTS-1:0]         dst_ready_i,
  input  logic [N_PORTS*DATA_W-1:0]  src_data_i,
  output logic [N_PORTS-1:0]         grant_o,
  output logic [N_PORTS*IDX_W-1:0]   xbar_sel_o,
  output logic [IDX_W-1:0]           slot_offset_o,
  output logic [N_PORTS*DATA_W-1:0]  dst_data_o,
  output logic [N_PORTS-1:0]         dst_valid_o
);
  logic                     slot_first;
  logic [N_PORTS*IDX_W-1:0] src_dst;

  ebs_slot_timer #(
    .N_PORTS(N_PORTS), .SLOT_CYCLES(SLOT_CYCLES), .IDX_W(IDX_W), .CYC_W(CYC_W)
  ) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .slot_first_o(slot_first), .offset_o(slot_offset_o)
  );

  ebs_perm_map #(.N_PORTS(N_PORTS), .IDX_W(IDX_W)) u_map (
    .offset_i(slot_offset_o), .dst_src_o(xbar_sel_o), .src_dst_o(src_dst)
  );

  ebs_grant_xbar #(.N_PORTS(N_PORTS), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_xbar (
    .clk_i(clk_i), .rst_ni(rst_ni), .slot_first_i(slot_first),
    .frag_avail_i(frag_avail_i), .dst_ready_i(dst_ready_i),
    .src_dst_i(src_dst), .dst_src_i(xbar_sel_o), .src_data_i(src_data_i),
    .grant_o(grant_o), .dst_data_o(dst_data_o), .dst_valid_o(dst_valid_o)
  );
endmodule

// File: rtl/ebs_sched_chk.sv
module ebs_sched_chk
  import ebs_pkg::*;
#(
  parameter int unsigned N_PORTS     = 4,
  parameter int unsigned SLOT_CYCLES = 4,
  parameter int unsigned DATA_W      = 16,
  localparam int unsigned IDX_W      = (N_PORTS > 1) ? $clog2(N_PORTS) : 1,
  localparam int unsigned CYC_W      = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [N_PORTS-1:0]       dst_ready_i,
  input logic [N_PORTS-1:0]       grant_o,
  input logic [N_PORTS*IDX_W-1:0] xbar_sel_o,
  input logic [IDX_W-1:0]         slot_offset_o,
  input logic [N_PORTS-1:0]       dst_valid_o
);
  logic [CYC_W-1:0]   cnt_q;
  logic [N_PORTS-1:0] hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                cnt_q <= '0;
    else if (cnt_q == CYC_W'(SLOT_CYCLES - 1))  cnt_q <= '0;
    else                                        cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    hit = '0;
    for (int d = 0; d < N_PORTS; d++) hit[xbar_sel_o[d*IDX_W +: IDX_W]] = 1'b1;
  end

  a_r3_sel_permutation: assert property (@(posedge clk_i) disable iff (!rst_ni) &hit);

  a_r2_offset_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != CYC_W'(SLOT_CYCLES - 1)) |=> $stable(slot_offset_o));

  a_r2_offset_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CYC_W'(SLOT_CYCLES - 1)) |=>
      (slot_offset_o == (($past(slot_offset_o) == IDX_W'(N_PORTS - 1)) ? '0 : $past(slot_offset_o) + 1'b1)));

  a_r4_grant_slot_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |-> (grant_o == '0));

  a_r6_valid_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != CYC_W'(SLOT_CYCLES - 1)) |=> $stable(dst_valid_o));

  for (genvar g = 0; g < N_PORTS; g++) begin : g_rdy
    a_r5_grant_needs_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grant_o[g] |-> dst_ready_i[mod_add(g, 32'(slot_offset_o), N_PORTS)]);
  end
endmodule

bind bshift_evb_sched ebs_sched_chk #(
  .N_PORTS(N_PORTS), .SLOT_CYCLES(SLOT_CYCLES), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/bshift_evb_sched_tb.sv
module bshift_evb_sched_tb;
  localparam int N  = 4;
  localparam int S  = 4;
  localparam int DW = 8;
  localparam int IW = 2;
  localparam int NSLOT = 40;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic [N*N-1:0]  frag_avail_i = '0;
  logic [N-1:0]    dst_ready_i = '0;
  logic [N*DW-1:0] src_data_i = '0;
  logic [N-1:0]    grant_o;
  logic [N*IW-1:0] xbar_sel_o;
  logic [IW-1:0]   slot_offset_o;
  logic [N*DW-1:0] dst_data_o;
  logic [N-1:0]    dst_valid_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bshift_evb_sched #(.N_PORTS(N), .SLOT_CYCLES(S), .DATA_W(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .frag_avail_i(frag_avail_i), .dst_ready_i(dst_ready_i),
    .src_data_i(src_data_i), .grant_o(grant_o), .xbar_sel_o(xbar_sel_o),
    .slot_offset_o(slot_offset_o), .dst_data_o(dst_data_o), .dst_valid_o(dst_valid_o)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N-1:0]   exp_hold;
    logic [N*N-1:0] seen;
    exp_hold = '0;
    seen = '0;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(slot_offset_o == 0, "R1", "offset in reset", int'(slot_offset_o), 0);
    for (int d = 0; d < N; d++)
      chk(int'(xbar_sel_o[d*IW +: IW]) == d, "R1", "identity select in reset", int'(xbar_sel_o[d*IW +: IW]), d);
    chk(grant_o == 0, "R1", "grant in reset", int'(grant_o), 0);
    chk(dst_valid_o == 0, "R1", "valid in reset", int'(dst_valid_o), 0);

    @(negedge clk);
    rst_ni = 1'b1;
    for (int k = 0; k < NSLOT * S; k++) begin
      int slot, off;
      bit first;
      string rq;
      logic [N-1:0] eg, ev, hit;
      if (k != 0) @(negedge clk);
      slot  = k / S;
      first = (k % S) == 0;
      off   = slot % N;
      src_data_i = {$urandom, $urandom};
      if (slot < 8) begin
        frag_avail_i = '1; dst_ready_i = '1; rq = "R4";
      end else if (slot < 16 || slot >= 24) begin
        frag_avail_i = N*N'($urandom); dst_ready_i = N'($urandom); rq = "R4";
      end else if (slot < 20) begin
        // only fragments for a destination other than the mapped one
        frag_avail_i = '0;
        for (int i = 0; i < N; i++) frag_avail_i[i*N + (i + off + 1) % N] = 1'b1;
        for (int i = 0; i < N; i++) frag_avail_i[i*N + (i + off + 2) % N] = $urandom_range(0, 1) == 1;
        dst_ready_i = '1; rq = "R8";
      end else begin
        frag_avail_i = '1; dst_ready_i = '0; rq = "R5";
      end
      #1;
      chk(int'(slot_offset_o) == off, "R2", "slot offset", int'(slot_offset_o), off);
      hit = '0;
      for (int d = 0; d < N; d++) begin
        int es;
        es = (d - off + N) % N;
        chk(int'(xbar_sel_o[d*IW +: IW]) == es, "R3", "select field", int'(xbar_sel_o[d*IW +: IW]), es);
        hit[xbar_sel_o[d*IW +: IW]] = 1'b1;
      end
      chk(hit == '1, "R3", "select permutation", int'(hit), (1 << N) - 1);
      for (int i = 0; i < N; i++) begin
        int m;
        m = (i + off) % N;
        eg[i] = first && frag_avail_i[i*N + m] && dst_ready_i[m];
      end
      chk(grant_o == eg, rq, "grant vector", int'(grant_o), int'(eg));
      if (first) exp_hold = eg;
      for (int d = 0; d < N; d++) begin
        int es;
        es = (d - off + N) % N;
        ev[d] = exp_hold[es];
        chk(dst_data_o[d*DW +: DW] == src_data_i[es*DW +: DW], "R6", "routed data",
            int'(dst_data_o[d*DW +: DW]), int'(src_data_i[es*DW +: DW]));
      end
      chk(dst_valid_o == ev, "R6", "valid vector", int'(dst_valid_o), int'(ev));
      if (first) begin
        if (slot > 0 && slot % N == 0) begin
          chk(seen == '1, "R7", "all pairs visited", int'(seen), (1 << (N*N)) - 1);
          seen = '0;
        end
        for (int i = 0; i < N; i++) begin
          chk(!seen[i*N + (i + off) % N], "R7", "pair visited twice", 1, 0);
          seen[i*N + (i + off) % N] = 1'b1;
        end
      end
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule